// File: doc/BRIEF.md
# Bus Clock Generator with Synchronizers

This block runs from a fast oscillator clock and produces two slower clocks from it. The processor clock is one third of the oscillator rate and is high for one oscillator period out of three. The peripheral clock is half the processor clock and has an even duty cycle. The oscillator itself is also passed straight through to an output. All derived outputs are registered on the oscillator edge, so they behave as clean, glitch-free clock-enable-style waveforms.

The block also conditions two control paths for the processor. An asynchronous reset request goes through a synchronizer chain that advances only on processor-clock rising edges. A hold counter then stretches the reset output so that it outlasts the request by a minimum number of processor cycles. Two ready sources can each be forced ready by their own enable. Their combination is registered on the processor clock, so the processor sees a stable level when it samples for wait-state insertion.

A synchronous active-high `init` input places the dividers at a known phase. It also starts the first reset hold period, as happens at power-up.

Top module: `busclk_gen`

## Requirements
- R1: `cpu_clk` repeats every 3 oscillator cycles (parameter CPU_DIV), high for one cycle and low for the other two.
- R2: `per_clk` toggles exactly on the oscillator edges where `cpu_clk` rises, which gives a period of 6 oscillator cycles and 50% duty. Every rising edge of `per_clk` coincides with a rising edge of `cpu_clk`.
- R3: `osc_out` follows `osc_clk` unchanged at all times.
- R4: While `init` is high, the next edge sets `cpu_clk`=1, `per_clk`=0, `rst_out`=1 and `rdy_out`=0. After `init` is released, `cpu_clk` is low on the 1st and 2nd oscillator edges and rises on the 3rd, where `per_clk` also rises.
- R5: `rst_out` changes only on oscillator edges where `cpu_clk` rises.
- R6: `rst_req` passes through a 2-stage synchronizer clocked by processor-clock rising edges. `rst_out` goes high within 3 processor cycles of a held request. After the request drops, `rst_out` stays high for at least 4 processor cycles (12 oscillator cycles) and falls no later than the 6th processor rising edge after release.
- R7: After `init` is released, `rst_out` stays high through the 11th oscillator edge and falls on the 12th, which completes the first 4-cycle hold.
- R8: On each `cpu_clk` rising edge, `rdy_out` loads (`rdy_a` OR `en_a`) AND (`rdy_b` OR `en_b`). An enable at 1 makes its side count as ready regardless of that side's ready input.
- R9: `rdy_out` holds its value between `cpu_clk` rising edges, whatever the ready and enable inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fast oscillator clock; all registers use its rising edge |
| init | input | 1 | Synchronous active-high initialisation (power-up) |
| rst_req | input | 1 | Asynchronous reset request, active high |
| rdy_a | input | 1 | Ready request from source A |
| en_a | input | 1 | Enable that forces source A ready |
| rdy_b | input | 1 | Ready request from source B |
| en_b | input | 1 | Enable that forces source B ready |
| osc_out | output | 1 | Oscillator passed through |
| cpu_clk | output | 1 | Processor clock, oscillator / 3, one-third duty |
| per_clk | output | 1 | Peripheral clock, oscillator / 6, 50% duty |
| rst_out | output | 1 | Synchronized, stretched reset, active high |
| rdy_out | output | 1 | Registered combined ready |

## Verification
The bench builds the block with its defaults: divide-by-3, two synchronizer stages and a 4-cycle reset hold. With these values the whole power-up hold ends after twelve oscillator edges, so the exact cycle of the reset release can be checked edge by edge. A full request-and-release sequence, with its 12-to-17-cycle window, fits in a few dozen cycles. The short processor period also lets all sixteen ready/enable combinations run back to back. Each combination is aligned to a processor edge, so the hold between edges and the update at the next edge can both be observed.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

    // One ready source: a request and an enable that bypasses it.
    typedef struct packed {
        logic req;
        logic bypass;
    } rdy_src_t;

    // Derived clock bundle from the divider.
    typedef struct packed {
        logic cpu;   // processor clock level
        logic per;   // peripheral clock level
        logic tick;  // the coming oscillator edge is a processor rising edge
    } clk_bus_t;

    function automatic logic merge_ready(input rdy_src_t a, input rdy_src_t b);
        return (a.req | a.bypass) & (b.req | b.bypass);
    endfunction

endpackage

// File: rtl/busclk_div.sv
module busclk_div
    import busclk_pkg::*;
#(
    parameter int CPU_DIV = 3
) (
    input  logic     osc_clk,
    input  logic     init,
    output clk_bus_t clks
);
    localparam int PH_W = (CPU_DIV > 2) ? $clog2(CPU_DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CPU_DIV - 1);

    logic [PH_W-1:0] phase_q;
    logic            cpu_q;
    logic            per_q;
    logic            tick;

    assign tick = (phase_q == PH_LAST);

    always_ff @(posedge osc_clk) begin
        if (init) begin
            phase_q <= '0;
            cpu_q   <= 1'b1;
            per_q   <= 1'b0;
        end else begin
            phase_q <= tick ? '0 : phase_q + 1'b1;
            cpu_q   <= tick;
            per_q   <= per_q ^ tick;
        end
    end

    always_comb begin
        clks.cpu  = cpu_q;
        clks.per  = per_q;
        clks.tick = tick;
    end
endmodule

// File: rtl/busclk_rst.sv
module busclk_rst #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 4
) (
    input  logic osc_clk,
    input  logic init,
    input  logic tick,
    input  logic rst_req,
    output logic rst_out
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_MAX  = CW'(HOLD_CYCLES);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          hold_q;
    logic                   rst_q;
    logic                   req_synced;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge osc_clk) begin
                if (init)      sync_q <= '0;
                else if (tick) sync_q <= {sync_q[SYNC_STAGES-2:0], rst_req};
            end
        end else begin : g_single
            always_ff @(posedge osc_clk) begin
                if (init)      sync_q <= '0;
                else if (tick) sync_q <= rst_req;
            end
        end
    endgenerate

    assign req_synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge osc_clk) begin
        if (init) begin
            hold_q <= '0;
            rst_q  <= 1'b1;
        end else if (tick) begin
            if (req_synced) begin
                hold_q <= '0;
                rst_q  <= 1'b1;
            end else begin
                if (hold_q != HOLD_MAX) hold_q <= hold_q + 1'b1;
                rst_q <= (hold_q < HOLD_LAST);
            end
        end
    end

    assign rst_out = rst_q;
endmodule

// File: rtl/busclk_rdy.sv
module busclk_rdy
    import busclk_pkg::*;
(
    input  logic     osc_clk,
    input  logic     init,
    input  logic     tick,
    input  rdy_src_t src_a,
    input  rdy_src_t src_b,
    output logic     rdy_out
);
    logic rdy_q;

    always_ff @(posedge osc_clk) begin
        if (init)      rdy_q <= 1'b0;
        else if (tick) rdy_q <= merge_ready(src_a, src_b);
    end

    assign rdy_out = rdy_q;
endmodule

// File: rtl/busclk_gen.sv
module busclk_gen
    import busclk_pkg::*;
#(
    parameter int CPU_DIV     = 3,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 4
) (
    input  logic osc_clk,
    input  logic init,
    input  logic rst_req,
    input  logic rdy_a,
    input  logic en_a,
    input  logic rdy_b,
    input  logic en_b,
    output logic osc_out,
    output logic cpu_clk,
    output logic per_clk,
    output logic rst_out,
    output logic rdy_out
);
    clk_bus_t clks;
    rdy_src_t src_a;
    rdy_src_t src_b;

    assign src_a = '{req: rdy_a, bypass: en_a};
    assign src_b = '{req: rdy_b, bypass: en_b};

    busclk_div #(.CPU_DIV(CPU_DIV)) u_div (
        .osc_clk (osc_clk),
        .init    (init),
        .clks    (clks)
    );

    busclk_rst #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(HOLD_CYCLES)) u_rst (
        .osc_clk (osc_clk),
        .init    (init),
        .tick    (clks.tick),
        .rst_req (rst_req),
        .rst_out (rst_out)
    );

    busclk_rdy u_rdy (
        .osc_clk (osc_clk),
        .init    (init),
        .tick    (clks.tick),
        .src_a   (src_a),
        .src_b   (src_b),
        .rdy_out (rdy_out)
    );

    assign osc_out = osc_clk;
    assign cpu_clk = clks.cpu;
    assign per_clk = clks.per;
endmodule

// File: rtl/busclk_gen_chk.sv
module busclk_gen_chk #(
    parameter int HOLD_CYCLES = 4
) (
    input logic osc_clk,
    input logic init,
    input logic rst_req,
    input logic rdy_a,
    input logic en_a,
    input logic rdy_b,
    input logic en_b,
    input logic cpu_clk,
    input logic per_clk,
    input logic rst_out,
    input logic rdy_out
);
    localparam int RW = $clog2(HOLD_CYCLES + 2) + 1;

    logic          cpu_prev;
    logic [RW-1:0] rises_q;

    // Count processor rising edges seen since the reset request last stood high.
    always_ff @(posedge osc_clk) begin
        cpu_prev <= cpu_clk;
        if (init || rst_req) rises_q <= '0;
        else if (cpu_clk && !cpu_prev && rises_q != {RW{1'b1}}) rises_q <= rises_q + 1'b1;
    end

    p_cpu_high_r1: assert property (@(posedge osc_clk) disable iff (init)
        cpu_clk |=> !cpu_clk);
    p_cpu_low_r1: assert property (@(posedge osc_clk) disable iff (init)
        (!cpu_clk && $past(!cpu_clk)) |=> cpu_clk);
    p_per_rise_r2: assert property (@(posedge osc_clk) disable iff (init)
        $rose(per_clk) |-> $rose(cpu_clk));
    p_per_change_r2: assert property (@(posedge osc_clk) disable iff (init)
        !$stable(per_clk) |-> $rose(cpu_clk));
    p_init_state_r4: assert property (@(posedge osc_clk)
        init |=> (cpu_clk && !per_clk && rst_out && !rdy_out));
    p_rst_align_r5: assert property (@(posedge osc_clk) disable iff (init)
        !$stable(rst_out) |-> $rose(cpu_clk));
    p_rst_hold_r6: assert property (@(posedge osc_clk) disable iff (init)
        $fell(rst_out) |-> (rises_q >= RW'(HOLD_CYCLES - 1)));
    p_rdy_value_r8: assert property (@(posedge osc_clk) disable iff (init)
        $rose(cpu_clk) |-> rdy_out == $past((rdy_a | en_a) & (rdy_b | en_b)));
    p_rdy_align_r9: assert property (@(posedge osc_clk) disable iff (init)
        !$stable(rdy_out) |-> $rose(cpu_clk));
endmodule

bind busclk_gen busclk_gen_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .osc_clk (osc_clk),
    .init    (init),
    .rst_req (rst_req),
    .rdy_a   (rdy_a),
    .en_a    (en_a),
    .rdy_b   (rdy_b),
    .en_b    (en_b),
    .cpu_clk (cpu_clk),
    .per_clk (per_clk),
    .rst_out (rst_out),
    .rdy_out (rdy_out)
);

// File: tb/busclk_gen_test.sv
`timescale 1ns/1ps
module busclk_gen_test;
    logic osc_clk = 1'b0;
    logic init    = 1'b1;
    logic rst_req = 1'b0;
    logic rdy_a = 1'b0, en_a = 1'b0, rdy_b = 1'b0, en_b = 1'b0;
    logic osc_out, cpu_clk, per_clk, rst_out, rdy_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 osc_clk = ~osc_clk;

    busclk_gen uut (
        .osc_clk (osc_clk), .init (init), .rst_req (rst_req),
        .rdy_a (rdy_a), .en_a (en_a), .rdy_b (rdy_b), .en_b (en_b),
        .osc_out (osc_out), .cpu_clk (cpu_clk), .per_clk (per_clk),
        .rst_out (rst_out), .rdy_out (rdy_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_init();
        @(negedge osc_clk);
        init = 1'b1;
        repeat (3) @(negedge osc_clk);
        init = 1'b0;
    endtask

    // R4: initial state and phase; R1, R2, R7: waveform after release
    task automatic t_powerup();
        @(negedge osc_clk);
        init = 1'b1;
        repeat (3) @(negedge osc_clk);
        check("R4 cpu_clk", cpu_clk, 1'b1);
        check("R4 per_clk", per_clk, 1'b0);
        check("R4 rst_out", rst_out, 1'b1);
        check("R4 rdy_out", rdy_out, 1'b0);
        init = 1'b0;
        for (int k = 1; k <= 13; k++) begin
            @(negedge osc_clk);
            check("R1 cpu_clk phase", cpu_clk, (k % 3) == 0);
            check("R2 per_clk phase", per_clk, ((k / 3) % 2) == 1);
            check("R7 power-up hold", rst_out, k < 12);
        end
    endtask

    // R3: oscillator pass-through on both levels
    task automatic t_passthru();
        for (int i = 0; i < 3; i++) begin
            @(negedge osc_clk);
            #0.5;
            check("R3 osc low", osc_out, 1'b0);
            @(posedge osc_clk);
            #0.5;
            check("R3 osc high", osc_out, 1'b1);
        end
    endtask

    // R6: request assertion and stretched release
    task automatic t_reset_req();
        int n;
        @(negedge osc_clk);
        rst_req = 1'b1;
        repeat (10) @(negedge osc_clk);
        check("R6 asserted", rst_out, 1'b1);
        rst_req = 1'b0;
        n = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge osc_clk);
            if (rst_out) n++;
            else break;
        end
        checks++;
        if (n < 12 || n > 17) begin
            fails++;
            $display("FAIL R6: reset held %0d osc cycles, expected 12..17", n);
        end
        check("R6 released", rst_out, 1'b0);
    endtask

    // R8, R9: every ready/enable combination
    task automatic t_ready();
        for (int c = 0; c < 16; c++) begin
            logic prev, exp;
            @(posedge cpu_clk);
            @(negedge osc_clk);
            prev = rdy_out;
            {rdy_a, en_a, rdy_b, en_b} = 4'(c);
            exp = (rdy_a | en_a) & (rdy_b | en_b);
            @(negedge osc_clk);
            check("R9 hold between edges", rdy_out, prev);
            repeat (2) @(negedge osc_clk);
            check("R8 combined ready", rdy_out, exp);
        end
    endtask

    initial begin
        t_powerup();
        t_passthru();
        t_reset_req();
        t_ready();
        do_init();
        t_powerup();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge osc_clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule